// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

The block translates 32-bit virtual addresses into 30-bit physical addresses. Every virtual address is split into a 20-bit page number, bits 31..12, and a 12-bit in-page offset, bits 11..0. All sixteen entries compare the page number in parallel. Each entry also holds a process tag, read/write/execute rights, a supervisor-only flag, a reference bit and a dirty bit. A lookup that matches returns the 18-bit physical page joined to the untouched offset, provided the requested access is allowed. If the access is not allowed, an access fault is reported instead. A lookup that matches nothing reports a miss, so that an outside page-table walker can refill the entry.

Translations are loaded through a fill port. A fill takes the lowest-numbered free entry. When all entries are valid, it replaces a victim chosen by a free-running linear feedback shift register. For context switches, the buffer can either invalidate every entry in one cycle or purge only the entries that carry a given process tag. Each lookup response appears on the outputs one clock after the request.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup presented in cycle t is answered in cycle t+1 with exactly one of resp_hit, resp_miss or resp_fault, and resp_valid is high. On a hit, resp_paddr is {stored 18-bit physical page, lk_vaddr[11:0]}.
- R2: A hit requires a valid entry whose page number equals lk_vaddr[31:12] and whose process tag equals lk_pid. A matching page number under another process tag is a miss.
- R3: A miss is a single-cycle resp_miss pulse with resp_paddr, resp_ref and resp_dirty at zero. It changes no valid, reference or dirty bit.
- R4: lk_kind selects the required right: 2'b00 read, 2'b01 write, 2'b10 execute, 2'b11 read. fill_perm holds the rights as bit 2 read, bit 1 write, bit 0 execute. A match without the required right gives resp_fault.
- R5: An entry filled with fill_sup_only=1 faults on every access made with lk_super=0, and translates normally when lk_super=1.
- R6: A fault takes priority over a hit. It returns resp_hit=0, resp_paddr=0 and resp_ref=resp_dirty=0, and it sets neither the reference bit nor the dirty bit.
- R7: Every hit sets the entry's reference bit. resp_ref reports the bit as it stood before this access, so it reads 0 on the first hit after a fill.
- R8: A write hit sets the entry's dirty bit. resp_dirty reports the bit as it stood before this access.
- R9: flush_all invalidates every entry, so all later lookups miss until a new fill.
- R10: purge_valid invalidates only the entries whose process tag equals purge_pid. Other entries keep translating.
- R11: A fill writes into the lowest-numbered invalid entry when one exists, so sixteen distinct fills after a flush all stay resident.
- R12: A fill into a full buffer replaces exactly one entry, chosen by a 4-bit LFSR that steps every cycle. The new translation hits, and exactly fifteen of the previous sixteen still hit.
- R13: After reset all entries are invalid and every response output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 read |
| lk_super | input | 1 | Request made in supervisor mode |
| lk_pid | input | 4 | Process tag of the running context |
| fill_valid | input | 1 | Load one translation |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 18 | Physical page number to load |
| fill_pid | input | 4 | Process tag of the loaded entry |
| fill_perm | input | 3 | Rights: bit 2 read, bit 1 write, bit 0 execute |
| fill_sup_only | input | 1 | Entry reachable only in supervisor mode |
| flush_all | input | 1 | Invalidate every entry |
| purge_valid | input | 1 | Invalidate entries of one process |
| purge_pid | input | 4 | Process tag to purge |
| resp_valid | output | 1 | A response is present this cycle |
| resp_hit | output | 1 | Translation succeeded |
| resp_miss | output | 1 | No entry matched |
| resp_fault | output | 1 | Entry matched but the access is not allowed |
| resp_paddr | output | 30 | Translated physical address |
| resp_ref | output | 1 | Reference bit before this access |
| resp_dirty | output | 1 | Dirty bit before this access |

## Verification
The properties assume that no two valid entries ever hold the same page number under the same process tag. The bench keeps to this by always filling distinct page and tag pairs. The properties on miss, dirty-bit and free-slot behaviour cover only cycles in which no fill, flush or purge happens together with the event they watch. The stimulus applies one operation per cycle with an idle cycle between operations, so those overlaps never occur. The replacement check depends only on the count of surviving translations, never on which slot the LFSR picked.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PERM_R = 2;
  localparam int PERM_W = 1;
  localparam int PERM_X = 0;

  // Rights check: the reserved kind is treated as a read.
  function automatic logic access_ok(input logic [2:0] perm, input logic sup_only,
                                     input logic [1:0] kind, input logic is_super);
    logic need;
    case (kind)
      ACC_WRITE: need = perm[PERM_W];
      ACC_EXEC:  need = perm[PERM_X];
      default:   need = perm[PERM_R];
    endcase
    return need && (!sup_only || is_super);
  endfunction

  // Galois feedback masks giving a maximal-length sequence per width.
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      2:       return 32'h3;
      3:       return 32'h6;
      4:       return 32'hC;
      5:       return 32'h14;
      6:       return 32'h30;
      7:       return 32'h60;
      default: return 32'hB8;
    endcase
  endfunction

endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 4
) (
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_vpn,
  input  logic [ENTRIES-1:0][PID_W-1:0] tag_pid,
  input  logic [VPN_W-1:0]              key_vpn,
  input  logic [PID_W-1:0]              key_pid,
  output logic [ENTRIES-1:0]            match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
  end
endmodule

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS = W'(tlb_pkg::lfsr_taps(W));

  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= W'(1);
    else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign state = state_q;

  a_r12_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0) else $error("victim LFSR locked at zero");

  a_r12_lfsr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_q != $past(state_q)) else $error("victim LFSR did not advance");
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  parameter int PID_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic             lk_super,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [2:0]       fill_perm,
  input  logic             fill_sup_only,
  input  logic             flush_all,
  input  logic             purge_valid,
  input  logic [PID_W-1:0] purge_pid,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_ref,
  output logic             resp_dirty
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // Entry storage
  logic [ENTRIES-1:0]            valid_q, ref_q, dirty_q, sup_q;
  logic [ENTRIES-1:0]            valid_d, ref_d, dirty_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [ENTRIES-1:0][2:0]       perm_q;

  // Named internal events
  logic [VPN_W-1:0]   key_vpn;
  logic [OFF_W-1:0]   key_off;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, free_any, allowed;
  logic [IDX_W-1:0]   hit_idx, free_idx, rnd_idx, victim_idx;
  logic               lk_hit, lk_miss, lk_fault, lk_write;

  assign key_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign key_off = lk_vaddr[OFF_W-1:0];

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam (
    .valid_vec(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
    .key_vpn(key_vpn), .key_pid(lk_pid), .match_vec(hit_vec)
  );

  tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
    .vec(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
    .vec(~valid_q), .any(free_any), .idx(free_idx)
  );

  tlb_victim_lfsr #(.W(IDX_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd_idx)
  );

  assign victim_idx = free_any ? free_idx : rnd_idx;
  assign allowed    = access_ok(perm_q[hit_idx], sup_q[hit_idx], lk_kind, lk_super);
  assign lk_hit     = lk_valid && hit_any && allowed;
  assign lk_fault   = lk_valid && hit_any && !allowed;
  assign lk_miss    = lk_valid && !hit_any;
  assign lk_write   = (lk_kind == ACC_WRITE);

  // Next state of the status bits: lookup update, then purge, fill, flush.
  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (lk_hit) begin
      ref_d[hit_idx] = 1'b1;
      if (lk_write) dirty_d[hit_idx] = 1'b1;
    end
    if (purge_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (pid_q[i] == purge_pid) valid_d[i] = 1'b0;
      end
    end
    if (fill_valid) begin
      valid_d[victim_idx] = 1'b1;
      ref_d[victim_idx]   = 1'b0;
      dirty_d[victim_idx] = 1'b0;
    end
    if (flush_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[victim_idx]  <= fill_vpn;
      ppn_q[victim_idx]  <= fill_ppn;
      pid_q[victim_idx]  <= fill_pid;
      perm_q[victim_idx] <= fill_perm;
      sup_q[victim_idx]  <= fill_sup_only;
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      resp_ref   <= 1'b0;
      resp_dirty <= 1'b0;
    end else begin
      resp_valid <= lk_valid;
      resp_hit   <= lk_hit;
      resp_miss  <= lk_miss;
      resp_fault <= lk_fault;
      resp_paddr <= lk_hit ? {ppn_q[hit_idx], key_off} : '0;
      resp_ref   <= lk_hit && ref_q[hit_idx];
      resp_dirty <= lk_hit && dirty_q[hit_idx];
    end
  end

  // Assertions
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == (resp_hit || resp_miss || resp_fault) && $onehot0({resp_hit, resp_miss, resp_fault}))
    else $error("response flags inconsistent");

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> resp_paddr[OFF_W-1:0] == $past(key_off)) else $error("offset altered");

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(hit_vec)) else $error("duplicate translation present");

  a_r3_miss_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss && !fill_valid && !flush_all && !purge_valid)
      |=> $stable(valid_q) && $stable(ref_q) && $stable(dirty_q)) else $error("miss changed state");

  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_paddr == '0 && !resp_ref && !resp_dirty) else $error("fault leaked data");

  a_r8_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !fill_valid && !flush_all && !purge_valid)
      |=> dirty_q[$past(hit_idx)] && ref_q[$past(hit_idx)]) else $error("write hit did not mark entry");

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0) else $error("flush left entries valid");

  a_r11_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(&valid_q) && !flush_all && !purge_valid)
      |=> $countones(valid_q) == $past($countones(valid_q)) + 1) else $error("fill overwrote a live entry");

  a_r12_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (&valid_q) && !flush_all && !purge_valid) |=> &valid_q)
    else $error("replacement dropped an entry");
endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_super = 1'b0;
  logic [3:0]  lk_pid = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic [3:0]  fill_pid = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_sup_only = 1'b0;
  logic        flush_all = 1'b0;
  logic        purge_valid = 1'b0;
  logic [3:0]  purge_pid = '0;
  logic        resp_valid, resp_hit, resp_miss, resp_fault, resp_ref, resp_dirty;
  logic [29:0] resp_paddr;

  always #2.5 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_super(lk_super), .lk_pid(lk_pid), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_pid(fill_pid), .fill_perm(fill_perm),
    .fill_sup_only(fill_sup_only), .flush_all(flush_all), .purge_valid(purge_valid),
    .purge_pid(purge_pid), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_miss(resp_miss), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .resp_ref(resp_ref), .resp_dirty(resp_dirty)
  );

  typedef struct {
    logic        hit, miss, fault, rf, dt;
    logic [29:0] pa;
    bit          tally;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   old_hits = 0;
  bit   done = 1'b0;
  bit   prev_lk = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: queue the expectation, then present the request for one cycle.
  task automatic lookup(input logic [31:0] va, input logic [1:0] k, input logic sup,
                        input logic [3:0] pid, input logic eh, input logic em, input logic ef,
                        input logic [29:0] epa, input logic er, input logic ed,
                        input string req, input bit tally = 1'b0);
    exp_t it;
    @(negedge clk);
    it.hit = eh; it.miss = em; it.fault = ef; it.pa = epa; it.rf = er; it.dt = ed;
    it.tally = tally; it.req = req;
    exp_q.push_back(it);
    lk_vaddr = va; lk_kind = k; lk_super = sup; lk_pid = pid; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn, input logic [3:0] pid,
                      input logic [2:0] perm, input logic so);
    @(negedge clk);
    fill_vpn = vpn; fill_ppn = ppn; fill_pid = pid; fill_perm = perm; fill_sup_only = so;
    fill_valid = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic do_purge(input logic [3:0] pid);
    @(negedge clk); purge_pid = pid; purge_valid = 1'b1;
    @(negedge clk); purge_valid = 1'b0;
  endtask

  // Monitor: a request seen at an edge is answered by that same edge.
  always @(posedge clk) begin
    if (lk_valid === 1'b1 && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      #2;
      if (it.tally) begin
        if (resp_hit) old_hits++;
        chk(!resp_fault, {it.req, " tally lookup faulted"}, 64'(resp_fault), 64'(0));
      end else begin
        chk(resp_valid && resp_hit == it.hit && resp_miss == it.miss && resp_fault == it.fault
            && resp_paddr == it.pa && resp_ref == it.rf && resp_dirty == it.dt, it.req,
            {27'(0), resp_hit, resp_miss, resp_fault, resp_ref, resp_dirty, resp_paddr},
            {27'(0), it.hit, it.miss, it.fault, it.rf, it.dt, it.pa});
      end
      prev_lk = 1'b1;
    end else begin
      #2;
      if (prev_lk) chk(!resp_valid && !resp_miss && !resp_hit && !resp_fault,
                       "R3 response lasts one cycle", 64'(resp_valid), 64'(0));
      prev_lk = 1'b0;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_valid && !resp_hit && !resp_miss && !resp_fault && resp_paddr == '0,
        "R13 reset outputs", 64'(resp_valid), 64'(0));
    lookup(32'h1234_5ABC, 2'b00, 1'b0, 4'd1, 0, 1, 0, '0, 0, 0, "R13 empty after reset");

    // Basic translation, reference and dirty tracking
    fill(20'h12345, 18'h2ABCD, 4'd1, 3'b111, 1'b0);
    lookup(32'h1234_5ABC, 2'b00, 1'b0, 4'd1, 1, 0, 0, {18'h2ABCD, 12'hABC}, 0, 0, "R1 R7 first read hit");
    lookup(32'h1234_5001, 2'b01, 1'b0, 4'd1, 1, 0, 0, {18'h2ABCD, 12'h001}, 1, 0, "R8 write hit, prior clean");
    lookup(32'h1234_5FFF, 2'b00, 1'b0, 4'd1, 1, 0, 0, {18'h2ABCD, 12'hFFF}, 1, 1, "R8 dirty after write");
    lookup(32'h1234_5ABC, 2'b00, 1'b0, 4'd2, 0, 1, 0, '0, 0, 0, "R2 other process misses");
    lookup(32'h1234_6ABC, 2'b00, 1'b0, 4'd1, 0, 1, 0, '0, 0, 0, "R2 R3 other page misses");
    lookup(32'h1234_5010, 2'b10, 1'b0, 4'd1, 1, 0, 0, {18'h2ABCD, 12'h010}, 1, 1, "R3 R4 exec hit, state kept");

    // Rights checks on a read-only page
    fill(20'h00400, 18'h00011, 4'd1, 3'b100, 1'b0);
    lookup(32'h0040_0123, 2'b01, 1'b0, 4'd1, 0, 0, 1, '0, 0, 0, "R4 R6 write to read-only faults");
    lookup(32'h0040_0123, 2'b10, 1'b0, 4'd1, 0, 0, 1, '0, 0, 0, "R4 exec without right faults");
    lookup(32'h0040_0123, 2'b11, 1'b0, 4'd1, 1, 0, 0, {18'h00011, 12'h123}, 0, 0, "R4 R6 reserved kind reads, faults left no mark");

    // Supervisor-only page
    fill(20'h7FFFF, 18'h3FFFF, 4'd3, 3'b111, 1'b1);
    lookup(32'h7FFF_F800, 2'b00, 1'b0, 4'd3, 0, 0, 1, '0, 0, 0, "R5 user access faults");
    lookup(32'h7FFF_F800, 2'b00, 1'b1, 4'd3, 1, 0, 0, {18'h3FFFF, 12'h800}, 0, 0, "R5 supervisor access hits");

    // Purge by process, then flush
    do_purge(4'd1);
    lookup(32'h1234_5ABC, 2'b00, 1'b0, 4'd1, 0, 1, 0, '0, 0, 0, "R10 purged entry misses");
    lookup(32'h0040_0123, 2'b00, 1'b0, 4'd1, 0, 1, 0, '0, 0, 0, "R10 second purged entry misses");
    lookup(32'h7FFF_F004, 2'b00, 1'b1, 4'd3, 1, 0, 0, {18'h3FFFF, 12'h004}, 1, 0, "R10 other process kept");
    do_flush();
    lookup(32'h7FFF_F004, 2'b00, 1'b1, 4'd3, 0, 1, 0, '0, 0, 0, "R9 flush invalidates all");

    // Fill every slot, then force a replacement
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 18'(i), 4'd5, 3'b111, 1'b0);
    for (int i = 0; i < 16; i++)
      lookup({20'h00100 + 20'(i), 12'h034}, 2'b00, 1'b0, 4'd5, 1, 0, 0, {18'(i), 12'h034}, 0, 0,
             "R11 all sixteen resident");
    fill(20'h00200, 18'h00077, 4'd5, 3'b111, 1'b0);
    lookup(32'h0020_0034, 2'b00, 1'b0, 4'd5, 1, 0, 0, {18'h00077, 12'h034}, 0, 0, "R12 new entry hits");
    for (int i = 0; i < 16; i++)
      lookup({20'h00100 + 20'(i), 12'h034}, 2'b00, 1'b0, 4'd5, 0, 0, 0, '0, 0, 0, "R12", 1'b1);
    repeat (4) @(negedge clk);
    chk(old_hits == 15, "R12 exactly one entry replaced", 64'(old_hits), 64'(15));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule